// File: doc/BRIEF.md
# General-Purpose I/O Register Block

This block gives software control over 32 general-purpose pins through a small set of 32-bit registers on a memory-mapped bus. The direction register marks each pin as an output (1) or an input (0). The level register holds the value that output pins drive. The level register cannot be written directly. Software changes it through two write-only ports, one that raises bits and one that lowers them. A spare read/write scratch word sits higher in the map. Three more offsets, reserved for edge detection, accept writes and do nothing with them.

The bus uses a valid/ready handshake. The block is always ready, so every request is accepted in the cycle it is presented. A read returns its data one cycle after it is accepted. Any access the map does not allow produces a one-cycle pulse on `err`, as does a set or clear write whose mask overlaps no output pin. Such a write leaves the level register untouched. When a set or clear write touches at least one output pin, its whole mask is applied, including the bits that belong to input pins.

Each pin has a pad driver that is enabled from its direction bit. The interrupt outputs are present so that the block fits the surrounding interrupt wiring, but they are held low.

Top module: `gpio_regblk`

## Requirements
- R1: After reset the level, direction and scratch registers all read zero, every `pad_oe` bit is 0 and `err` is low.
- R2: Word offset 0x04 is the direction register, which is read/write. `pad_oe` equals the direction register, bit for bit.
- R3: A write to 0x08 (set) whose data shares at least one 1 bit with the direction register ORs the complete data word into the level register, including bits on input pins. No error is raised.
- R4: A write to 0x0C (clear) whose data shares at least one 1 bit with the direction register clears every level bit that is 1 in the data word. No error is raised.
- R5: A set or clear write whose data has no 1 bit in common with the direction register leaves the level register unchanged and pulses `err`.
- R6: Writes to 0x10, 0x14 and 0x18 change nothing and raise no error. Reads of those offsets return zero and pulse `err`.
- R7: A read from any offset other than 0x00, 0x04 or 0x20 returns zero and pulses `err`. A write to any offset other than 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x20 pulses `err` and changes nothing. This includes writes to 0x00.
- R8: Offset 0x20 is a 32-bit read/write scratch register with no other effect.
- R9: `req_ready` is always 1. Every accepted read gives `rsp_valid` high for exactly the following cycle, with `rsp_rdata` valid in that cycle. Writes give no `rsp_valid`.
- R10: For a pin marked as an output, `pad_out` equals its level bit. For an input pin, `pad_out` is 0.
- R11: All eight `irq_low` bits and `irq_high` stay 0.
- R12: Address bits [1:0] are ignored, so any byte address within a word selects that word.
- R13: `err` is high for exactly the one cycle that follows the offending accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 32 | Read data |
| err | output | 1 | One-cycle error pulse |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_low | output | 8 | Low-group interrupts, tied to 0 |
| irq_high | output | 1 | High-group interrupt, tied to 0 |

## Verification
Random set and clear masks run against random direction settings. Some masks are forced to miss every output pin, some hit only output pins, and some mix output and input pins. Together these separate a whole-mask gate from a per-bit gate and from an ungated update. Directed cases place single-bit masks on the lowest and highest pins and drive all pins as outputs and then all as inputs. Reads and writes sweep every mapped offset and several unmapped ones, including offset 0x00 for writes, the edge offsets for reads and addresses with nonzero low bits. These show whether the decoder tells read legality apart from write legality and whether it ignores the byte lane.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;

  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_EDGE,
    SEL_AUX,
    SEL_NONE
  } reg_sel_e;

  // A set or clear write takes effect only if its mask hits an output pin.
  function automatic logic mask_hits_output(input logic [31:0] mask,
                                            input logic [31:0] dir);
    return |(mask & dir);
  endfunction

  function automatic logic [31:0] level_after_set(input logic [31:0] level,
                                                  input logic [31:0] mask,
                                                  input logic [31:0] dir);
    return mask_hits_output(mask, dir) ? (level | mask) : level;
  endfunction

  function automatic logic [31:0] level_after_clr(input logic [31:0] level,
                                                  input logic [31:0] mask,
                                                  input logic [31:0] dir);
    return mask_hits_output(mask, dir) ? (level & ~mask) : level;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regblk_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output reg_sel_e          sel,
  output logic              rd_bad,
  output logic              wr_bad
);
  localparam logic [ADDR_W-1:0] W_LEVEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] W_DIR   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] W_SET   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] W_CLR   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] W_RISE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] W_FALL  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] W_EDST  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] W_AUX   = ADDR_W'(8);

  logic [ADDR_W-1:0] word_idx;
  assign word_idx = addr >> 2;

  always_comb begin
    sel = SEL_NONE;
    unique case (word_idx)
      W_LEVEL:                 sel = SEL_LEVEL;
      W_DIR:                   sel = SEL_DIR;
      W_SET:                   sel = SEL_SET;
      W_CLR:                   sel = SEL_CLR;
      W_RISE, W_FALL, W_EDST:  sel = SEL_EDGE;
      W_AUX:                   sel = SEL_AUX;
      default:                 sel = SEL_NONE;
    endcase
  end

  always_comb begin
    rd_bad = 1'b0;
    wr_bad = 1'b0;
    if (write) begin
      wr_bad = (sel == SEL_LEVEL) || (sel == SEL_NONE);
    end else begin
      rd_bad = !((sel == SEL_LEVEL) || (sel == SEL_DIR) || (sel == SEL_AUX));
    end
  end
endmodule

// File: rtl/gpio_level_ctrl.sv
module gpio_level_ctrl
  import gpio_regblk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] level_q,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] aux_q,
  output logic              setclr_miss
);
  logic is_setclr;
  logic hit;

  assign is_setclr   = wr_en && ((sel == SEL_SET) || (sel == SEL_CLR));
  assign hit         = mask_hits_output(wdata, dir_q);
  assign setclr_miss = is_setclr && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '0;
      aux_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR: dir_q   <= wdata;
        SEL_AUX: aux_q   <= wdata;
        SEL_SET: level_q <= level_after_set(level_q, wdata, dir_q);
        SEL_CLR: level_q <= level_after_clr(level_q, wdata, dir_q);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int N_PINS = 32
) (
  input  logic [N_PINS-1:0] level,
  input  logic [N_PINS-1:0] dir,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pad_oe[i]  = dir[i];
    assign pad_out[i] = dir[i] ? level[i] : 1'b0;
  end
endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
  import gpio_regblk_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int IRQ_LOW_N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 err,
  output logic [DATA_W-1:0]    pad_out,
  output logic [DATA_W-1:0]    pad_oe,
  output logic [IRQ_LOW_N-1:0] irq_low,
  output logic                 irq_high
);
  reg_sel_e          sel;
  logic              rd_bad, wr_bad;
  logic              acc, acc_rd, acc_wr;
  logic              setclr_miss;
  logic              fault;
  logic [DATA_W-1:0] level_q, dir_q, aux_q;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = 1'b1;
  assign acc       = req_valid && req_ready;
  assign acc_rd    = acc && !req_write;
  assign acc_wr    = acc && req_write;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (req_addr),
    .write  (req_write),
    .sel    (sel),
    .rd_bad (rd_bad),
    .wr_bad (wr_bad)
  );

  gpio_level_ctrl #(.DATA_W(DATA_W)) u_lvl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (acc_wr),
    .sel         (sel),
    .wdata       (req_wdata),
    .level_q     (level_q),
    .dir_q       (dir_q),
    .aux_q       (aux_q),
    .setclr_miss (setclr_miss)
  );

  gpio_pad_drive #(.N_PINS(DATA_W)) u_pad (
    .level   (level_q),
    .dir     (dir_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  always_comb begin
    case (sel)
      SEL_LEVEL: rd_mux = level_q;
      SEL_DIR:   rd_mux = dir_q;
      SEL_AUX:   rd_mux = aux_q;
      default:   rd_mux = '0;
    endcase
  end

  assign fault = (acc_rd && rd_bad) || (acc_wr && (wr_bad || setclr_miss));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err       <= 1'b0;
    end else begin
      rsp_valid <= acc_rd;
      err       <= fault;
      if (acc_rd) rsp_rdata <= rd_mux;
    end
  end

  assign irq_low  = '0;
  assign irq_high = 1'b0;
endmodule

// File: rtl/gpio_regblk_chk.sv
module gpio_regblk_chk #(
  parameter int DATA_W    = 32,
  parameter int IRQ_LOW_N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 rsp_valid,
  input logic                 err,
  input logic                 setclr_miss,
  input logic [DATA_W-1:0]    level_q,
  input logic [DATA_W-1:0]    dir_q,
  input logic [DATA_W-1:0]    pad_out,
  input logic [DATA_W-1:0]    pad_oe,
  input logic [IRQ_LOW_N-1:0] irq_low,
  input logic                 irq_high
);
  a_r9_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r9_no_rsp_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r5_miss_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    setclr_miss |=> err);

  a_r5_miss_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    setclr_miss |=> $stable(level_q));

  a_r2_oe_is_dir: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe == dir_q);

  a_r10_inputs_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r11_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_low == '0) && !irq_high);

  a_r13_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !err);
endmodule

bind gpio_regblk gpio_regblk_chk #(.DATA_W(DATA_W), .IRQ_LOW_N(IRQ_LOW_N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .err         (err),
  .setclr_miss (setclr_miss),
  .level_q     (level_q),
  .dir_q       (dir_q),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .irq_low     (irq_low),
  .irq_high    (irq_high)
);

// File: tb/gpio_regblk_tb.sv
module gpio_regblk_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        err;
  logic [31:0] pad_out, pad_oe;
  logic [7:0]  irq_low;
  logic        irq_high;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_level = '0, m_dir = '0, m_aux = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err(err),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_low(irq_low), .irq_high(irq_high)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int word_of(input logic [11:0] a);
    return int'(a >> 2);
  endfunction

  function automatic bit read_ok(input int w);
    return (w == 0) || (w == 1) || (w == 8);
  endfunction

  function automatic bit write_known(input int w);
    return (w >= 1 && w <= 6) || (w == 8);
  endfunction

  task automatic check_pads(input string tag);
    check({tag, " R2 oe"}, pad_oe, m_dir);
    check({tag, " R10 out"}, pad_out, m_level & m_dir);
    check({tag, " R11 irq"}, {23'd0, irq_high, irq_low}, 32'd0);
  endtask

  // Inputs are driven at the falling edge; outputs are sampled at the next falling edge.
  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    int  w = word_of(a);
    bit  hit = |(d & m_dir);
    bit  e_err;
    e_err = !write_known(w) || ((w == 2 || w == 3) && !hit);
    if (w == 1) m_dir = d;
    if (w == 8) m_aux = d;
    if (w == 2 && hit) m_level = m_level | d;
    if (w == 3 && hit) m_level = m_level & ~d;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    check("R9 ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check((w == 2 || w == 3) ? "R5 err" : (w >= 4 && w <= 6) ? "R6 err" : "R7 err",
          {31'd0, err}, {31'd0, e_err});
    check("R9 no rsp on write", {31'd0, rsp_valid}, 32'd0);
    check_pads("wr");
    @(negedge clk);
    check("R13 err one cycle", {31'd0, err}, 32'd0);
  endtask

  task automatic do_read(input logic [11:0] a);
    int w = word_of(a);
    logic [31:0] e_data;
    e_data = (w == 0) ? m_level : (w == 1) ? m_dir : (w == 8) ? m_aux : 32'd0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = $urandom;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(read_ok(w) ? "R8 R12 rdata" : "R7 rdata", rsp_rdata, e_data);
    check(read_ok(w) ? "R7 err" : "R6 R7 err", {31'd0, err}, {31'd0, !read_ok(w)});
    check_pads("rd");
    @(negedge clk);
    check("R9 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 err", {31'd0, err}, 32'd0);
    check("R1 oe", pad_oe, 32'd0);
    do_read(12'h000); do_read(12'h004); do_read(12'h020);

    // R5: set/clear with no outputs
    do_write(12'h008, 32'hFFFF_FFFF);
    do_write(12'h00C, 32'h0000_0001);
    do_read(12'h000);
    // R2, R3: whole-mask gate, input bits get set too
    do_write(12'h004, 32'h0000_00F0);
    do_read(12'h004);
    do_write(12'h008, 32'h8000_0010);
    do_read(12'h000);
    do_write(12'h008, 32'h0000_000F);          // R5 miss
    do_read(12'h000);
    // R4: clear lowers input bits too when mask hits an output
    do_write(12'h00C, 32'h8000_0010);
    do_read(12'h000);
    // Boundary pins: bit 0 and bit 31
    do_write(12'h004, 32'h8000_0001);
    do_write(12'h008, 32'h8000_0000);
    do_write(12'h008, 32'h0000_0001);
    do_write(12'h00C, 32'h8000_0000);
    do_write(12'h004, 32'hFFFF_FFFF);
    do_write(12'h008, 32'hA5A5_5A5A);
    do_read(12'h000);
    // R6: edge offsets
    do_write(12'h010, 32'hFFFF_FFFF); do_write(12'h014, 32'h1234_5678); do_write(12'h018, 32'h1);
    do_read(12'h010); do_read(12'h014); do_read(12'h018);
    do_read(12'h000); do_read(12'h004);
    // R7: unmapped, including writes to level
    do_write(12'h000, 32'hFFFF_FFFF); do_write(12'h01C, 32'h1); do_write(12'h024, 32'h1);
    do_write(12'hFFC, 32'h1);
    do_read(12'h008); do_read(12'h00C); do_read(12'h01C); do_read(12'h800);
    do_read(12'h000); do_read(12'h004);
    // R8 + R12: scratch register, byte lanes ignored
    do_write(12'h023, 32'hDEAD_BEEF);
    do_read(12'h021);
    do_write(12'h005, 32'h0000_0000);
    do_read(12'h006);

    // Random traffic
    for (int i = 0; i < 1500; i++) begin
      int pick = $urandom % 11;
      logic [11:0] a;
      logic [31:0] d = $urandom;
      case (pick)
        0: a = 12'h000;  1: a = 12'h004;  2: a = 12'h008;  3: a = 12'h00C;
        4: a = 12'h010;  5: a = 12'h014;  6: a = 12'h018;  7: a = 12'h01C;
        8: a = 12'h020;  9: a = 12'h008 | 12'(($urandom % 2) * 4);
        default: a = 12'($urandom);
      endcase
      a = a | 12'($urandom % 4);
      case ($urandom % 4)
        0: d = d & ~m_dir;           // force a miss
        1: d = d & m_dir;            // outputs only
        2: d = d & $urandom;         // sparse mixed mask
        default: ;
      endcase
      if ($urandom % 2) do_write(a, d); else do_read(a);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule